// File: doc/BRIEF.md
# Context-Decision Pair Compactor and Serializer

This block sits between a wide context-formation stage and an arithmetic encoder that consumes one symbol per clock. Each cycle the upstream stage may offer a group of up to `SLOTS` slots (40 by default). Each slot carries one context/decision pair, and a mask marks which slots are populated. The block captures the group and picks out only the populated slots. It hands them to the encoder one per cycle, lowest slot first, under a valid/ready handshake.

While a captured group still holds pairs beyond the one leaving this cycle, the block raises a stall towards the upstream stage. The stall drops in the cycle the last pair is taken, so the next group loads in that same cycle and the encoder sees no gap between groups. A group with no populated slots is absorbed in one cycle without any stall. An idle flag tells the encoder side that no pair is on offer.

Top module: `ctxdec_compactor`

## Requirements
- R1: After reset, out_valid is 0, cf_stall is 0 and ae_idle is 1.
- R2: Only slots whose mask bit is 1 are emitted, strictly in ascending slot index order within a group.
- R3: Each populated slot is emitted exactly once, and one pair leaves per cycle in which out_valid and out_ready are both 1. Over a run, the emitted count equals the sum of the populations of the accepted groups.
- R4: While out_valid is 1 and out_ready is 0, out_valid, out_ctx and out_dec hold their values into the next cycle.
- R5: cf_stall is 1 exactly when the held group still has a pair that will not leave in the current cycle. A group is accepted on a clock edge where in_valid is 1 and cf_stall is 0.
- R6: A group with an all-zero mask is accepted in one cycle without raising cf_stall, and it produces no output. ae_idle is 1 exactly when out_valid is 0, and cf_stall is never 1 while ae_idle is 1.
- R7: When a group with at least one populated slot is accepted, out_valid is 1 in the next cycle with that group's lowest populated slot. This includes the cycle right after the previous group's last pair was taken.
- R8: Slot k occupies in_pairs bits [6k+5:6k]. Bits [6k+5:6k+1] are the 5-bit context label and bit 6k is the decision. These appear unchanged on out_ctx and out_dec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A group is presented |
| in_mask | input | SLOTS | Populated-slot mask of the presented group |
| in_pairs | input | SLOTS*6 | Packed pairs, slot k at bits [6k+5:6k] |
| cf_stall | output | 1 | Upstream must hold its group |
| out_valid | output | 1 | A pair is offered to the encoder |
| out_ready | input | 1 | Encoder takes the offered pair |
| out_ctx | output | 5 | Context label of the offered pair |
| out_dec | output | 1 | Decision bit of the offered pair |
| ae_idle | output | 1 | No pair is available to the encoder |

## Verification
The two functions that share a cycle are taking the last pair of a group and loading the next group. The stall must fall combinationally as the final handshake happens, and the new group must appear on the next edge. This is provoked with a directed sequence of group populations 4, 2, 0, 0, 0, 2, 1, 2, 0, 0 under a permanently ready encoder. It is also provoked by random runs where the upstream holds its group until accepted and ready toggles. A bench model predicts the stall and the offered pair each cycle, and an explicit no-gap check flags any empty cycle after a populated group is accepted.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int CTX_W  = 5;
  localparam int PAIR_W = CTX_W + 1;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic             dec;
  } pair_t;
endpackage

// File: rtl/ccd_lowest_sel.sv
// Lowest-set-bit selector: one-hot of the first populated slot plus an any flag.
module ccd_lowest_sel #(
  parameter int SLOTS = 40
) (
  input  logic [SLOTS-1:0] mask,
  output logic [SLOTS-1:0] onehot,
  output logic             any
);
  logic [SLOTS:0] seen;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_chain
      assign onehot[i]  = mask[i] & ~seen[i];
      assign seen[i+1]  = seen[i] | mask[i];
    end
  endgenerate

  assign any = seen[SLOTS];
endmodule

// File: rtl/ccd_pair_mux.sv
// AND-OR multiplexer picking one pair with a one-hot select.
module ccd_pair_mux
  import ccd_pkg::*;
#(
  parameter int SLOTS = 40
) (
  input  logic [SLOTS*PAIR_W-1:0] pairs,
  input  logic [SLOTS-1:0]        sel,
  output logic [PAIR_W-1:0]       pick
);
  logic [PAIR_W-1:0] acc [SLOTS+1];

  assign acc[0] = '0;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_or
      assign acc[i+1] = acc[i] | ({PAIR_W{sel[i]}} & pairs[i*PAIR_W +: PAIR_W]);
    end
  endgenerate

  assign pick = acc[SLOTS];
endmodule

// File: rtl/ccd_hold_buf.sv
// Holds the current group: remaining-slot mask and the pair payload.
module ccd_hold_buf
  import ccd_pkg::*;
#(
  parameter int SLOTS = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [SLOTS-1:0]        load_mask,
  input  logic [SLOTS*PAIR_W-1:0] load_pairs,
  input  logic [SLOTS-1:0]        drain_mask,
  output logic [SLOTS-1:0]        mask_q,
  output logic [SLOTS*PAIR_W-1:0] pairs_q
);
  logic [SLOTS-1:0]        mask_d;
  logic [SLOTS*PAIR_W-1:0] pairs_d;

  always_comb begin
    mask_d  = drain_mask;
    pairs_d = pairs_q;
    if (load) begin
      mask_d  = load_mask;
      pairs_d = load_pairs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pairs_q <= '0;
    end else if (load) begin
      pairs_q <= pairs_d;
    end
  end
endmodule

// File: rtl/ctxdec_compactor.sv
// Compacts a sparse group of context/decision slots into a one-per-cycle stream.
module ctxdec_compactor
  import ccd_pkg::*;
#(
  parameter int SLOTS = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [SLOTS-1:0]        in_mask,
  input  logic [SLOTS*PAIR_W-1:0] in_pairs,
  output logic                    cf_stall,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [CTX_W-1:0]        out_ctx,
  output logic                    out_dec,
  output logic                    ae_idle
);
  logic [SLOTS-1:0]        mask_q;
  logic [SLOTS*PAIR_W-1:0] pairs_q;
  logic [SLOTS-1:0]        first_oh;
  logic                    have_pair;
  logic [PAIR_W-1:0]       pick_raw;
  pair_t                   pick;
  logic                    take;
  logic [SLOTS-1:0]        drain_mask;
  logic                    accept;

  ccd_lowest_sel #(.SLOTS(SLOTS)) u_sel (
    .mask   (mask_q),
    .onehot (first_oh),
    .any    (have_pair)
  );

  ccd_pair_mux #(.SLOTS(SLOTS)) u_mux (
    .pairs (pairs_q),
    .sel   (first_oh),
    .pick  (pick_raw)
  );

  // Remaining slots after this cycle's handshake; non-empty means hold upstream.
  always_comb begin
    take       = have_pair & out_ready;
    drain_mask = take ? (mask_q & ~first_oh) : mask_q;
    cf_stall   = |drain_mask;
    accept     = in_valid & ~cf_stall;
  end

  ccd_hold_buf #(.SLOTS(SLOTS)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_mask  (in_mask),
    .load_pairs (in_pairs),
    .drain_mask (drain_mask),
    .mask_q     (mask_q),
    .pairs_q    (pairs_q)
  );

  assign pick      = pair_t'(pick_raw);
  assign out_valid = have_pair;
  assign out_ctx   = pick.ctx;
  assign out_dec   = pick.dec;
  assign ae_idle   = ~have_pair;
endmodule

// File: rtl/ctxdec_compactor_chk.sv
module ctxdec_compactor_chk
  import ccd_pkg::*;
#(
  parameter int SLOTS = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [SLOTS-1:0] in_mask,
  input logic             cf_stall,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CTX_W-1:0] out_ctx,
  input logic             out_dec,
  input logic             ae_idle
);
  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ctx) && $stable(out_dec))); // R4

  AST_STALL_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    cf_stall |-> out_valid); // R5

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ae_idle |-> !cf_stall); // R6

  AST_EMPTY_GROUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cf_stall && (in_mask == '0)) |=> !out_valid); // R6

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cf_stall && (in_mask != '0)) |=> out_valid); // R7
endmodule

bind ctxdec_compactor ctxdec_compactor_chk #(.SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_mask   (in_mask),
  .cf_stall  (cf_stall),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_ctx   (out_ctx),
  .out_dec   (out_dec),
  .ae_idle   (ae_idle)
);

// File: tb/ctxdec_compactor_bench.sv
`timescale 1ns/1ps
module ctxdec_compactor_bench;
  localparam int S  = 40;
  localparam int PW = 6;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [S-1:0]    in_mask;
  logic [S*PW-1:0] in_pairs;
  logic            cf_stall;
  logic            out_valid;
  logic            out_ready;
  logic [4:0]      out_ctx;
  logic            out_dec;
  logic            ae_idle;

  ctxdec_compactor #(.SLOTS(S)) u_ctxdec_compactor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask),
    .in_pairs(in_pairs), .cf_stall(cf_stall), .out_valid(out_valid),
    .out_ready(out_ready), .out_ctx(out_ctx), .out_dec(out_dec), .ae_idle(ae_idle)
  );

  int checks = 0;
  int fails  = 0;
  int emitted = 0;
  int expected_total = 0;

  logic [S-1:0]    mdl_mask;
  logic [S*PW-1:0] mdl_pairs;
  logic            hold_prev;
  logic [4:0]      prev_ctx;
  logic            prev_dec;
  logic            prev_loaded_full;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [S-1:0] m);
    for (int i = 0; i < S; i++) if (m[i]) return i;
    return 0;
  endfunction

  // One cycle: drive at negedge, check, advance model at the edge.
  task automatic step(input logic v, input logic [S-1:0] m, input logic [S*PW-1:0] d,
                      input logic r, output logic acc);
    logic       ev;
    int         idx;
    logic [S-1:0] drain;
    logic       es;
    logic [5:0] pr;
    in_valid = v; in_mask = m; in_pairs = d; out_ready = r;
    #1;
    ev  = (mdl_mask != '0);
    idx = lowest(mdl_mask);
    pr  = mdl_pairs[idx*PW +: PW];
    chk(out_valid == ev, "R2 out_valid", out_valid, ev);
    if (ev) begin
      chk(out_ctx == pr[5:1], "R8 out_ctx", out_ctx, pr[5:1]);
      chk(out_dec == pr[0], "R2 out_dec", out_dec, pr[0]);
    end
    drain = mdl_mask;
    if (ev && r) drain[idx] = 1'b0;
    es = (drain != '0);
    chk(cf_stall == es, "R5 cf_stall", cf_stall, es);
    chk(ae_idle == !ev, "R6 ae_idle", ae_idle, !ev);
    if (hold_prev)
      chk(out_valid && out_ctx == prev_ctx && out_dec == prev_dec, "R4 hold",
          {out_valid, out_ctx, out_dec}, {1'b1, prev_ctx, prev_dec});
    if (prev_loaded_full)
      chk(out_valid == 1'b1, "R7 no gap", out_valid, 1);
    if (ev && r) emitted++;
    acc = v && !es;
    hold_prev = ev && !r;
    prev_ctx = out_ctx;
    prev_dec = out_dec;
    prev_loaded_full = acc && (m != '0);
    if (acc) begin
      expected_total += $countones(m);
      mdl_mask  = m;
      mdl_pairs = d;
    end else begin
      mdl_mask = drain;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [S*PW-1:0] rand_pairs();
    logic [S*PW-1:0] x;
    for (int i = 0; i < S; i++) x[i*PW +: PW] = 6'($urandom);
    return x;
  endfunction

  function automatic logic [S-1:0] spread_mask(input int k);
    logic [S-1:0] mm = '0;
    for (int i = 0; i < k; i++) mm[(i*7 + 3) % S] = 1'b1;
    return mm;
  endfunction

  initial begin
    int watch = 0;
    while (watch < 150000) begin
      @(posedge clk);
      watch++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", watch, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic acc;
    logic cur_v;
    logic [S-1:0] cur_m;
    logic [S*PW-1:0] cur_d;
    int pops [10] = '{4, 2, 0, 0, 0, 2, 1, 2, 0, 0};
    void'($urandom(32'h5eed_1234));
    mdl_mask = '0; mdl_pairs = '0;
    hold_prev = 1'b0; prev_loaded_full = 1'b0; prev_ctx = '0; prev_dec = 1'b0;
    in_valid = 1'b0; in_mask = '0; in_pairs = '0; out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(cf_stall == 1'b0, "R1 cf_stall", cf_stall, 0);
    chk(ae_idle == 1'b1, "R1 ae_idle", ae_idle, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: varying populations, encoder always ready (R7 overlap, R6 empties).
    for (int g = 0; g < 10; g++) begin
      cur_m = spread_mask(pops[g]);
      cur_d = rand_pairs();
      acc = 1'b0;
      while (!acc) step(1'b1, cur_m, cur_d, 1'b1, acc);
    end
    // Directed boundaries: full group, top slot only, bottom slot only with blocked ready.
    acc = 1'b0;
    cur_d = rand_pairs();
    while (!acc) step(1'b1, '1, cur_d, 1'b1, acc);
    acc = 1'b0;
    cur_m = '0; cur_m[S-1] = 1'b1; cur_d = rand_pairs();
    while (!acc) step(1'b1, cur_m, cur_d, 1'b1, acc);
    acc = 1'b0;
    cur_m = '0; cur_m[0] = 1'b1; cur_d = rand_pairs();
    while (!acc) step(1'b1, cur_m, cur_d, 1'b1, acc);
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, 1'b0, acc);
    step(1'b0, '0, '0, 1'b1, acc);

    // Random phase: upstream holds its group until accepted.
    cur_v = 1'b0; cur_m = '0; cur_d = '0;
    for (int n = 0; n < 4000; n++) begin
      if (!cur_v || acc) begin
        cur_v = ($urandom % 5) != 0;
        case ($urandom % 4)
          0: cur_m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
          1: cur_m = {$urandom, $urandom} | {$urandom, $urandom};
          2: cur_m = '0;
          default: cur_m = ($urandom % 2) ? '1 : spread_mask(1 + $urandom % 3);
        endcase
        cur_d = rand_pairs();
      end
      step(cur_v, cur_m, cur_d, ($urandom % 4) != 0, acc);
    end
    for (int i = 0; i < S + 4; i++) step(1'b0, '0, '0, 1'b1, acc);
    chk(emitted == expected_total, "R3 pair count", emitted, expected_total);
    chk(ae_idle == 1'b1, "R6 drained idle", ae_idle, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule